// File: doc/BRIEF.md
# Cartridge Bus DMA Controller

This block is a register-programmed copy engine. It moves bytes between a main-memory port and a cartridge-side port, and it can copy in either direction. Software uses a 32-bit register bus to load a main-memory address and a cartridge address. It then starts a copy by writing one of two length registers, and the register it writes selects the direction. When the copy is done, the interrupt line goes high.

When a copy starts, the engine takes aligned internal copies of both addresses. It shortens the requested length by the low three bits of the aligned main-memory address, then moves one byte per clock. Both byte ports read combinationally: the engine drives an address and receives the data in the same cycle. The visible address registers advance only at completion. Each one becomes its internal copy plus the effective length.

Top module: `cart_dma`

## Requirements
- R1: After reset, every register reads as zero. The interrupt output and both write strobes are low.
- R2: Offset 0x00 holds the main-memory address and offset 0x04 holds the cartridge address. Each is written and read back as a full 32-bit value.
- R3: Writing offset 0x08 or 0x0C starts a copy when the engine is idle.
  - The effective length is the low LEN_W bits of the written value plus one.
  - It is then reduced by bits [2:0] of the latched main-memory address (main-memory register AND 0x007FFFFE), with a floor of zero.
  - The effective length reads back from the offset that was written.
- R4: The status register is at offset 0x10.
  - Bit 0 and bit 1 both show busy, bit 2 always reads 0 and bit 3 shows the pending interrupt.
  - Busy reads 1 in the cycle after the starting write.
- R5: A copy started through 0x08 works as follows for byte i, counting from 0.
  - Byte i is read from main memory at latched main-memory address + i.
  - It is written to the cartridge side at latched cartridge address + i, where the cartridge address is the register AND 0xFFFFFFFE.
  - One byte moves per clock.
- R6: A copy started through 0x0C reads byte i from the cartridge side at latched cartridge address + i. It writes that byte to main memory at latched main-memory address + i.
- R7: A copy of N bytes keeps busy high for N+1 cycles. Busy then clears, the interrupt rises, and both address registers read as their latched copies plus N.
- R8: A write to either length register while busy has no effect on the running copy or on either stored length.
- R9: Writing the status register has two effects.
  - With bit 1 set, it clears the pending interrupt.
  - With bit 0 set, it stops a running copy: busy clears, no further bytes move, no interrupt is raised and the address registers are left unchanged.
- R10: A copy whose effective length is zero moves no byte. It completes one cycle after the start.
- R11: The two write strobes are never high together, and neither is high while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| mem_addr | output | 32 | Main-memory byte address |
| mem_rdata | input | 8 | Main-memory read byte |
| mem_wdata | output | 8 | Main-memory write byte |
| mem_we | output | 1 | Main-memory write strobe |
| cart_addr | output | 32 | Cartridge-side byte address |
| cart_rdata | input | 8 | Cartridge-side read byte |
| cart_wdata | output | 8 | Cartridge-side write byte |
| cart_we | output | 1 | Cartridge-side write strobe |
| irq | output | 1 | Pending completion interrupt |

## Verification
The bench builds the block with its default parameters: a 24-bit length field and the standard address masks. Because the bench memories are only 256 bytes, short copies are enough to reach the cases of interest:
- misaligned main-memory addresses that shorten the length;
- the floor at zero length;
- a stop in the middle of a copy;
- writes that arrive while the engine is busy.

Exact busy-cycle counts can be checked in a few dozen clocks.

// File: rtl/cart_dma.sv
module cart_dma #(
  parameter int          LEN_W     = 24,
  parameter logic [31:0] MEM_MASK  = 32'h007F_FFFE,
  parameter logic [31:0] CART_MASK = 32'hFFFF_FFFE,
  localparam int         CNT_W     = LEN_W + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [31:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic [31:0] cart_addr,
  input  logic [7:0]  cart_rdata,
  output logic [7:0]  cart_wdata,
  output logic        cart_we,
  output logic        irq
);

  logic [31:0]      mem_reg, cart_reg, mem_base, cart_base;
  logic [CNT_W-1:0] m2c_len, c2m_len, len_q, cnt;
  logic             busy, to_mem, irq_q;

  wire hit_m2c = reg_wr && reg_addr == 5'h08;
  wire hit_c2m = reg_wr && reg_addr == 5'h0C;
  wire hit_st  = reg_wr && reg_addr == 5'h10;
  wire start   = (hit_m2c || hit_c2m) && !busy;
  wire abort   = hit_st && reg_wdata[0];
  wire ack     = hit_st && reg_wdata[1];

  wire [31:0]      mem_lat  = mem_reg & MEM_MASK;
  wire [31:0]      cart_lat = cart_reg & CART_MASK;
  wire [CNT_W-1:0] raw_len  = {1'b0, reg_wdata[LEN_W-1:0]} + CNT_W'(1);
  wire [CNT_W-1:0] skew     = CNT_W'(mem_lat[2:0]);
  wire [CNT_W-1:0] eff_len  = (raw_len > skew) ? raw_len - skew : '0;

  wire moving = busy && cnt != len_q;
  wire finish = busy && cnt == len_q;

  assign mem_addr   = mem_base + 32'(cnt);
  assign cart_addr  = cart_base + 32'(cnt);
  assign mem_wdata  = cart_rdata;
  assign cart_wdata = mem_rdata;
  assign mem_we     = moving && to_mem;
  assign cart_we    = moving && !to_mem;
  assign irq        = irq_q;

  always_comb begin
    case (reg_addr)
      5'h00:   reg_rdata = mem_reg;
      5'h04:   reg_rdata = cart_reg;
      5'h08:   reg_rdata = 32'(m2c_len);
      5'h0C:   reg_rdata = 32'(c2m_len);
      5'h10:   reg_rdata = {28'd0, irq_q, 1'b0, busy, busy};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_reg   <= '0;
      cart_reg  <= '0;
      mem_base  <= '0;
      cart_base <= '0;
      m2c_len   <= '0;
      c2m_len   <= '0;
      len_q     <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
      to_mem    <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 5'h00) mem_reg  <= reg_wdata;
      if (reg_wr && reg_addr == 5'h04) cart_reg <= reg_wdata;
      if (start) begin
        mem_base  <= mem_lat;
        cart_base <= cart_lat;
        len_q     <= eff_len;
        cnt       <= '0;
        busy      <= 1'b1;
        to_mem    <= hit_c2m;
        if (hit_m2c) m2c_len <= eff_len;
        else         c2m_len <= eff_len;
      end else if (abort) begin
        busy <= 1'b0;
      end else if (moving) begin
        cnt <= cnt + CNT_W'(1);
      end else if (finish) begin
        busy     <= 1'b0;
        irq_q    <= 1'b1;
        mem_reg  <= mem_base + 32'(len_q);
        cart_reg <= cart_base + 32'(len_q);
      end
      if (ack) irq_q <= 1'b0;
    end
  end

endmodule

module cart_dma_chk #(
  parameter int CNT_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [4:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             mem_we,
  input logic             cart_we,
  input logic             irq,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] len_q
);

  wire len_wr = reg_wr && (reg_addr == 5'h08 || reg_addr == 5'h0C);
  wire st_wr  = reg_wr && reg_addr == 5'h10;

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, cart_we}));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_we || cart_we));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt <= len_q);

  assert_finish_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt == len_q && !st_wr |=> !busy && irq);

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && len_wr |=> busy);

  assert_ignored_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && len_wr |=> $stable(len_q));

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr && reg_wdata[0] |=> !busy);

  assert_zero_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && len_q == '0 |-> !(mem_we || cart_we));

endmodule

bind cart_dma cart_dma_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_we(mem_we), .cart_we(cart_we), .irq(irq),
  .busy(busy), .cnt(cnt), .len_q(len_q)
);

// File: tb/cart_dma_bench.sv
module cart_dma_bench;
  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [31:0] mem_addr, cart_addr;
  logic [7:0]  mem_rdata, mem_wdata, cart_rdata, cart_wdata;
  logic        mem_we, cart_we, irq;

  logic [7:0] mem_arr [256];
  logic [7:0] cart_arr[256];
  int checks = 0, fails = 0, strobes = 0, both = 0;

  always #2.5 clk = ~clk;

  cart_dma u_cart_dma (.*);

  assign mem_rdata  = mem_arr[mem_addr[7:0]];
  assign cart_rdata = cart_arr[cart_addr[7:0]];

  always @(posedge clk) begin
    if (mem_we)  mem_arr[mem_addr[7:0]]   <= mem_wdata;
    if (cart_we) cart_arr[cart_addr[7:0]] <= cart_wdata;
    if (mem_we || cart_we) strobes++;
    if (mem_we && cart_we) both++;
  end

  function automatic logic [7:0] mem_init(int i);  return 8'(i) ^ 8'hA5; endfunction
  function automatic logic [7:0] cart_init(int i); return 8'(i * 3) ^ 8'h5C; endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] s;
    n = 0;
    rd(5'h10, s);
    while (s[0] && n < 5000) begin
      n++; @(negedge clk); rd(5'h10, s);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a <= 16; a += 4) begin
      rd(5'(a), d); check("R1 reg after reset", d, 0);
    end
    check("R1 irq after reset", {31'd0, irq}, 0);
    check("R1 strobes after reset", {30'd0, mem_we, cart_we}, 0);
  endtask

  task automatic t_addr_regs;
    logic [31:0] d;
    wr(5'h00, 32'hDEADBEEF); rd(5'h00, d); check("R2 mem addr readback", d, 32'hDEADBEEF);
    wr(5'h04, 32'h1234_5677); rd(5'h04, d); check("R2 cart addr readback", d, 32'h1234_5677);
  endtask

  task automatic t_m2c;
    logic [31:0] d; int n; int ok;
    wr(5'h00, 32'h10); wr(5'h04, 32'h41);
    wr(5'h08, 32'h0100_0007);
    rd(5'h10, d); check("R4 status while busy", d, 32'h3);
    rd(5'h08, d); check("R3 m2c length", d, 8);
    wait_idle(n);
    check("R7 busy cycles", n, 9);
    ok = 1;
    for (int i = 0; i < 8; i++) if (cart_arr[8'h40 + i] !== mem_init(8'h10 + i)) ok = 0;
    check("R5 bytes copied to cart", ok, 1);
    check("R5 byte past end untouched", cart_arr[8'h48], cart_init(8'h48));
    rd(5'h00, d); check("R7 mem addr advanced", d, 32'h18);
    rd(5'h04, d); check("R7 cart addr advanced", d, 32'h48);
    rd(5'h10, d); check("R4 status after done", d, 32'h8);
    check("R7 irq raised", {31'd0, irq}, 1);
    wr(5'h10, 32'h2);
    check("R9 irq cleared", {31'd0, irq}, 0);
  endtask

  task automatic t_c2m;
    logic [31:0] d; int n; int ok;
    wr(5'h00, 32'h23); wr(5'h04, 32'h60);
    wr(5'h0C, 32'h9);
    wr(5'h08, 32'h3);
    wr(5'h0C, 32'h1);
    wait_idle(n);
    rd(5'h0C, d); check("R3 c2m length shortened", d, 8);
    rd(5'h08, d); check("R8 m2c length kept", d, 8);
    ok = 1;
    for (int i = 0; i < 8; i++) if (mem_arr[8'h22 + i] !== cart_init(8'h60 + i)) ok = 0;
    check("R6 bytes copied to mem", ok, 1);
    check("R6 byte past end untouched", mem_arr[8'h2A], mem_init(8'h2A));
    rd(5'h00, d); check("R7 mem addr from latched copy", d, 32'h2A);
    rd(5'h04, d); check("R8 cart addr from original copy", d, 32'h68);
    wr(5'h10, 32'h2);
  endtask

  task automatic t_abort;
    logic [31:0] d; int s;
    wr(5'h00, 32'h80); wr(5'h04, 32'h0);
    wr(5'h08, 32'h3F);
    repeat (3) @(negedge clk);
    wr(5'h10, 32'h1);
    rd(5'h10, d); check("R9 abort clears busy", d, 0);
    s = strobes;
    repeat (5) @(negedge clk);
    check("R9 no bytes after abort", s, strobes);
    check("R9 far byte untouched", cart_arr[8'h20], cart_init(8'h20));
    rd(5'h00, d); check("R9 mem addr unchanged", d, 32'h80);
    check("R9 no irq on abort", {31'd0, irq}, 0);
  endtask

  task automatic t_zero;
    logic [31:0] d; int n; int s;
    wr(5'h00, 32'h7); wr(5'h04, 32'h31);
    s = strobes;
    wr(5'h08, 32'h3);
    wait_idle(n);
    check("R10 busy one cycle", n, 1);
    check("R10 no strobes", strobes, s);
    rd(5'h08, d); check("R10 zero length", d, 0);
    rd(5'h00, d); check("R10 mem addr", d, 32'h6);
    rd(5'h04, d); check("R10 cart addr", d, 32'h30);
    check("R10 irq raised", {31'd0, irq}, 1);
    check("R11 strobes never together", both, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_arr[i] = mem_init(i); cart_arr[i] = cart_init(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    fork
      begin t_reset; t_addr_regs; t_m2c; t_c2m; t_abort; t_zero; end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule